// File: doc/BRIEF.md
# Receiver channel input qualifier

This block sits at the entrance of one receiver channel. It picks one of two input ports, each carrying a 14-bit sample, a 3-bit exponent and an enable line, and passes the chosen port's three signals on together. A 2-bit mode field then decides, clock by clock, whether a new sample is accepted, whether zeros are put in place of the input, and whether the downstream oscillator may advance its phase. The block also picks one of four external sync pins for the channel.

The outputs are a registered sample and exponent with a valid strobe, a phase-step strobe for the oscillator, a run enable for the decimating filters behind the block, and the chosen sync line. All configuration inputs are static fields that the surrounding register logic drives. Every output is registered and follows the input sampled at the clock edge before it.

Top module: `rx_input_qualifier`

## Requirements
- R1: With `cfg_port_sel` = 0 the sample, exponent and enable of port A feed the channel. With 1 they come from port B. All three always come from the same port.
- R2: Mode 2'b00 (blanking): `out_valid` is 1 on every clock. `out_data`/`out_exp` carry the input while the enable is high and are both zero while it is low. `run_en` equals the enable.
- R3: In mode 2'b00, `phase_step` is 1 on every clock, whatever the enable level.
- R4: Mode 2'b01 (level-gated): a sample is captured and `phase_step` is raised only on clocks where the enable is high. Otherwise `out_valid` and `phase_step` are 0 and `out_data`/`out_exp` keep their last value.
- R5: Mode 2'b10 (rising one-shot): exactly one sample is captured, on the first clock where the enable is high after a clock where it was low. `phase_step` is raised once with that capture only.
- R6: Mode 2'b11 (falling one-shot): like R5, on the first clock where the enable is low after a clock where it was high.
- R7: In modes 2'b01, 2'b10 and 2'b11, `run_en` is 1 on every clock, including clocks with no capture.
- R8: `cfg_sync_sel` values 0, 1, 2, 3 route `sync_pins[0]`..`sync_pins[3]` (pins A, B, C, D) to `sync_out`.
- R9: The first clock after reset never counts as an edge, so an enable that is already high when reset ends produces no rising-edge capture.
- R10: On the clock where `cfg_port_sel` changes, no edge is detected. After that, the newly selected port's enable is the reference for edges.
- R11: While reset is asserted, all outputs are 0.
- R12: Each output reflects the inputs sampled at the preceding rising clock edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Enable-handling mode |
| cfg_port_sel | input | 1 | 0 = port A, 1 = port B |
| cfg_sync_sel | input | 2 | Sync pin index |
| a_data | input | 14 | Port A sample |
| a_exp | input | 3 | Port A exponent |
| a_en | input | 1 | Port A enable |
| b_data | input | 14 | Port B sample |
| b_exp | input | 3 | Port B exponent |
| b_en | input | 1 | Port B enable |
| sync_pins | input | 4 | External sync pins A..D |
| out_data | output | 14 | Qualified sample |
| out_exp | output | 3 | Exponent travelling with the sample |
| out_valid | output | 1 | New sample strobe |
| phase_step | output | 1 | Oscillator phase-advance strobe |
| run_en | output | 1 | Back-end filter run enable |
| sync_out | output | 1 | Selected sync line |

## Verification
One continuous sequence steps the enable through high, low, held and toggled levels in each of the four modes. It shows that blanking zeroes the data but keeps the phase moving, that level gating holds the last sample, and that each one-shot mode fires exactly once per matching transition and not on a held level. Port switches are placed where the old and new enables differ, both low-to-high and high-to-low, so that a false edge would show up as a stray capture. Separate tests hold the enable high across reset and walk a single set sync pin through every selector value, also with the inverse pattern.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    MODE_BLANK = 2'b00,
    MODE_LEVEL = 2'b01,
    MODE_RISE  = 2'b10,
    MODE_FALL  = 2'b11
  } rxq_mode_t;
endpackage

// File: rtl/rxq_port_mux.sv
module rxq_port_mux #(
  parameter int DATA_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              sel,
  input  logic [DATA_W-1:0] a_data,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              a_en,
  input  logic [DATA_W-1:0] b_data,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic              b_en,
  output logic [DATA_W-1:0] s_data,
  output logic [EXP_W-1:0]  s_exp,
  output logic              s_en
);
  // R1: the whole port moves as one bundle
  always_comb begin
    if (sel) begin
      s_data = b_data;
      s_exp  = b_exp;
      s_en   = b_en;
    end else begin
      s_data = a_data;
      s_exp  = a_exp;
      s_en   = a_en;
    end
  end
endmodule

// File: rtl/rxq_enable_ctrl.sv
module rxq_enable_ctrl
  import rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rxq_mode_t mode,
  input  logic      sel,
  input  logic      en,
  output logic      take,
  output logic      zero,
  output logic      step,
  output logic      run
);
  logic en_prev;
  logic sel_prev;
  logic armed;
  logic edge_ok;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev  <= 1'b0;
      sel_prev <= 1'b0;
      armed    <= 1'b0;
    end else begin
      en_prev  <= en;
      sel_prev <= sel;
      armed    <= 1'b1;
    end
  end

  // R9 / R10: no edge on the first clock or on a port switch
  assign edge_ok = armed && (sel_prev == sel);
  assign rise    = edge_ok && en && !en_prev;
  assign fall    = edge_ok && !en && en_prev;

  always_comb begin
    take = 1'b0;
    zero = 1'b0;
    step = 1'b0;
    run  = 1'b1;
    unique case (mode)
      MODE_BLANK: begin
        take = 1'b1;
        zero = !en;
        step = 1'b1;
        run  = en;
      end
      MODE_LEVEL: begin
        take = en;
        step = en;
      end
      MODE_RISE: begin
        take = rise;
        step = rise;
      end
      MODE_FALL: begin
        take = fall;
        step = fall;
      end
      default: ;
    endcase
  end

  // R5: a one-shot capture is never followed by another one on the next clock
  p_one_shot_r5: assert property (@(posedge clk) disable iff (rst)
    (take && mode[1]) |=> (!take || (mode != $past(mode))));

  // R9: the first clock after reset never yields an edge capture
  p_no_edge_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !(rise || fall));
endmodule

// File: rtl/rx_input_qualifier.sv
module rx_input_qualifier
  import rxq_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int EXP_W    = 3,
  parameter int NUM_SYNC = 4,
  localparam int SYNC_SEL_W = $clog2(NUM_SYNC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_port_sel,
  input  logic [SYNC_SEL_W-1:0] cfg_sync_sel,
  input  logic [DATA_W-1:0]     a_data,
  input  logic [EXP_W-1:0]      a_exp,
  input  logic                  a_en,
  input  logic [DATA_W-1:0]     b_data,
  input  logic [EXP_W-1:0]      b_exp,
  input  logic                  b_en,
  input  logic [NUM_SYNC-1:0]   sync_pins,
  output logic [DATA_W-1:0]     out_data,
  output logic [EXP_W-1:0]      out_exp,
  output logic                  out_valid,
  output logic                  phase_step,
  output logic                  run_en,
  output logic                  sync_out
);
  logic [DATA_W-1:0] s_data;
  logic [EXP_W-1:0]  s_exp;
  logic              s_en;
  logic              take, zero, step, run;
  rxq_mode_t         mode;

  assign mode = rxq_mode_t'(cfg_mode);

  rxq_port_mux #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_mux (
    .sel    (cfg_port_sel),
    .a_data (a_data),
    .a_exp  (a_exp),
    .a_en   (a_en),
    .b_data (b_data),
    .b_exp  (b_exp),
    .b_en   (b_en),
    .s_data (s_data),
    .s_exp  (s_exp),
    .s_en   (s_en)
  );

  rxq_enable_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .sel  (cfg_port_sel),
    .en   (s_en),
    .take (take),
    .zero (zero),
    .step (step),
    .run  (run)
  );

  // R11 / R12: one registered stage, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      out_data   <= '0;
      out_exp    <= '0;
      out_valid  <= 1'b0;
      phase_step <= 1'b0;
      run_en     <= 1'b0;
      sync_out   <= 1'b0;
    end else begin
      out_valid  <= take;
      phase_step <= step;
      run_en     <= run;
      sync_out   <= sync_pins[cfg_sync_sel];
      if (take) begin
        out_data <= zero ? '0 : s_data;
        out_exp  <= zero ? '0 : s_exp;
      end
    end
  end

  p_blank_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b00 && !s_en) |=> (out_valid && out_data == '0 && out_exp == '0 && !run_en));

  p_blank_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b00) |=> phase_step);

  p_level_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b01 && !s_en) |=> (!out_valid && !phase_step && $stable(out_data)));

  p_step_with_sample_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode != 2'b00) |=> (phase_step == out_valid));

  p_run_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode != 2'b00) |=> run_en);

  p_sync_route_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sync_out == $past(sync_pins[cfg_sync_sel])));
endmodule

// File: tb/rx_input_qualifier_tb.sv
`timescale 1ns/1ps
module rx_input_qualifier_tb;
  typedef struct packed {
    logic [1:0]  mode;
    logic        sel;
    logic        aen;
    logic [13:0] adat;
    logic        ben;
    logic [13:0] bdat;
    logic        v;
    logic        st;
    logic        rn;
    logic [13:0] d;
    logic [2:0]  e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  // port A exponent is 5, port B exponent is 2
  localparam vec_t VECS [NV] = '{
    '{2'b00,1'b0,1'b1,14'h0100,1'b0,14'h0AAA,1'b1,1'b1,1'b1,14'h0100,3'd5,4'd2}, // R2 pass
    '{2'b00,1'b0,1'b0,14'h0123,1'b0,14'h0AAA,1'b1,1'b1,1'b0,14'h0000,3'd0,4'd3}, // R2/R3 blank
    '{2'b00,1'b1,1'b0,14'h0123,1'b1,14'h0AAA,1'b1,1'b1,1'b1,14'h0AAA,3'd2,4'd1}, // R1 port B
    '{2'b01,1'b0,1'b1,14'h1111,1'b0,14'h0AAA,1'b1,1'b1,1'b1,14'h1111,3'd5,4'd4}, // R4
    '{2'b01,1'b0,1'b0,14'h2222,1'b0,14'h0AAA,1'b0,1'b0,1'b1,14'h1111,3'd5,4'd7}, // R4/R7 hold
    '{2'b01,1'b0,1'b1,14'h3333,1'b0,14'h0AAA,1'b1,1'b1,1'b1,14'h3333,3'd5,4'd4}, // R4
    '{2'b10,1'b0,1'b1,14'h0444,1'b0,14'h0AAA,1'b0,1'b0,1'b1,14'h3333,3'd5,4'd5}, // R5 held high
    '{2'b10,1'b0,1'b0,14'h0555,1'b0,14'h0AAA,1'b0,1'b0,1'b1,14'h3333,3'd5,4'd5}, // R5
    '{2'b10,1'b0,1'b1,14'h0666,1'b0,14'h0AAA,1'b1,1'b1,1'b1,14'h0666,3'd5,4'd5}, // R5 rise
    '{2'b10,1'b0,1'b1,14'h0777,1'b0,14'h0AAA,1'b0,1'b0,1'b1,14'h0666,3'd5,4'd5}, // R5 once
    '{2'b11,1'b0,1'b1,14'h0888,1'b0,14'h0AAA,1'b0,1'b0,1'b1,14'h0666,3'd5,4'd6}, // R6
    '{2'b11,1'b0,1'b0,14'h0999,1'b0,14'h0AAA,1'b1,1'b1,1'b1,14'h0999,3'd5,4'd6}, // R6 fall
    '{2'b11,1'b0,1'b0,14'h0AAA,1'b0,14'h0AAA,1'b0,1'b0,1'b1,14'h0999,3'd5,4'd6}, // R6 once
    '{2'b10,1'b1,1'b0,14'h0AAA,1'b1,14'h1234,1'b0,1'b0,1'b1,14'h0999,3'd5,4'd10}, // R10 A0->B1
    '{2'b10,1'b1,1'b0,14'h0AAA,1'b1,14'h1235,1'b0,1'b0,1'b1,14'h0999,3'd5,4'd10}, // R10
    '{2'b10,1'b1,1'b0,14'h0AAA,1'b0,14'h1236,1'b0,1'b0,1'b1,14'h0999,3'd5,4'd5},
    '{2'b10,1'b1,1'b0,14'h0AAA,1'b1,14'h1FFF,1'b1,1'b1,1'b1,14'h1FFF,3'd2,4'd1}, // R1 via B
    '{2'b11,1'b0,1'b0,14'h0001,1'b1,14'h1FFF,1'b0,1'b0,1'b1,14'h1FFF,3'd2,4'd10}, // R10 B1->A0
    '{2'b01,1'b0,1'b1,14'h3FFF,1'b1,14'h1FFF,1'b1,1'b1,1'b1,14'h3FFF,3'd5,4'd12}  // R12
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_port_sel = 1'b0;
  logic [1:0]  cfg_sync_sel = 2'b00;
  logic [13:0] a_data = '0, b_data = '0;
  logic [2:0]  a_exp = 3'd5, b_exp = 3'd2;
  logic        a_en = 1'b0, b_en = 1'b0;
  logic [3:0]  sync_pins = '0;
  logic [13:0] out_data;
  logic [2:0]  out_exp;
  logic        out_valid, phase_step, run_en, sync_out;

  int n_total = 0;
  int n_pass  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rx_input_qualifier u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_port_sel(cfg_port_sel),
    .cfg_sync_sel(cfg_sync_sel), .a_data(a_data), .a_exp(a_exp), .a_en(a_en),
    .b_data(b_data), .b_exp(b_exp), .b_en(b_en), .sync_pins(sync_pins),
    .out_data(out_data), .out_exp(out_exp), .out_valid(out_valid),
    .phase_step(phase_step), .run_en(run_en), .sync_out(sync_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic apply(input vec_t v);
    cfg_mode = v.mode; cfg_port_sel = v.sel;
    a_en = v.aen; a_data = v.adat; b_en = v.ben; b_data = v.bdat;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset outputs", {26'd0, out_valid, phase_step, run_en, sync_out, |out_data, |out_exp}, 32'd0);

    rst = 1'b0;
    apply(VECS[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check($sformatf("R%0d vector %0d {v,st,rn,d,e}", VECS[i].req, i),
            {12'd0, out_valid, phase_step, run_en, out_data, out_exp},
            {12'd0, VECS[i].v, VECS[i].st, VECS[i].rn, VECS[i].d, VECS[i].e});
      if (i + 1 < NV) apply(VECS[i+1]);
    end

    // R9: enable high across reset in rising mode
    rst = 1'b1; cfg_mode = 2'b10; cfg_port_sel = 1'b0; a_en = 1'b1; a_data = 14'h0042;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 no capture on first clock", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R9 still no capture", {31'd0, out_valid}, 32'd0);
    a_en = 1'b0;
    @(negedge clk);
    a_en = 1'b1; a_data = 14'h0043;
    @(negedge clk);
    check("R5 real rise after reset", {17'd0, out_valid, out_data}, {17'd0, 1'b1, 14'h0043});

    // R8: sync pin mapping, one hot and inverse
    for (int s = 0; s < 4; s++) begin
      cfg_sync_sel = 2'(s);
      sync_pins = 4'b0001 << s;
      @(negedge clk);
      check($sformatf("R8 sync sel %0d one-hot", s), {31'd0, sync_out}, 32'd1);
      sync_pins = ~(4'b0001 << s);
      @(negedge clk);
      check($sformatf("R8 sync sel %0d inverse", s), {31'd0, sync_out}, 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule